// File: doc/BRIEF.md
# Sampling Converter Bus Sequencer

This block holds the digital side of an 8-bit two-step sampling converter. The analog path is replaced by an 8-bit code input and an over-range flag, both already digitised. The block decides when that code is sampled and tracks the two conversion halves with clock-cycle timers. It presents the result on a tri-state data bus and signals completion on an active-low interrupt. It also drives an open-drain ready line and an overflow flag. Tri-state and open-drain pins appear as a value plus an enable, so the block stays synthesizable.

A mode input selects between two bus protocols. In read-only mode a single stretched read samples the input, waits for the internal time-out and then shows the data. During that read the shared control pin acts as a ready output. In write-then-read mode a write strobe samples the input. The upper nibble is taken when the strobe rises, and the lower nibble is taken either when an internal delay expires or when an early read cuts the conversion short. Tying chip select and read low in this mode gives standalone operation, where each write pulse produces a fresh result on the bus.

The sequencer has five states:
- IDLE waits for a start.
- RO_CONV times the read-only conversion.
- RO_HOLD keeps the read-only result on the bus until the read ends.
- WR_LOW waits while the write strobe is low.
- LS_CONV times the lower-half conversion.

Its transitions are:
- IDLE to RO_CONV when mode is low and chip select and read are both low.
- IDLE to WR_LOW on a write falling edge with chip select low.
- RO_CONV to RO_HOLD when the time-out expires.
- RO_CONV to IDLE when chip select or read rises (abort).
- RO_HOLD to IDLE when chip select or read rises.
- WR_LOW to LS_CONV on the write rising edge.
- LS_CONV to IDLE when the lower-half timer expires or a read access begins.

Top module: `adc_bus_sequencer`

## Requirements
- R1: With mode_i high, holding cs_n_i and rd_n_i low never starts a conversion, and int_n_o stays high.
- R2: With mode_i low, code_i is sampled at the first clock edge where cs_n_i and rd_n_i are both low. int_n_o falls RO_CYC edges after that edge, and data_o then carries the sampled code. Later changes to code_i have no effect on that result.
- R3: In read-only mode, rdy_low_o (1 = pin pulled low) is 1 while cs_n_i is low and no finished result is held. It drops at the same edge int_n_o falls. With mode_i high it is always 0.
- R4: With mode_i high and cs_n_i low, code_i and ovr_i are sampled at the edge that sees wr_n_i fall. Later changes to either input have no effect on that result.
- R5: With no early read, int_n_o falls LS_CYC edges after the edge that sees wr_n_i rise. data_o then holds the upper nibble taken at that rise and the lower nibble of the sampled code.
- R6: If a read access (cs_n_i and rd_n_i both low, beginning with a fall of either) begins during the lower-half conversion, the result is latched and int_n_o falls at that edge.
- R7: int_n_o returns high at the edge that sees cs_n_i or rd_n_i rise, and at the edge that starts a new conversion.
- R8: data_oe_o is 1 exactly when cs_n_i and rd_n_i are both low.
- R9: At the end of each conversion ofl_n_o becomes the inverse of the sampled ovr_i. Between conversions ofl_n_o holds its value, and it is never tri-stated.
- R10: In write-then-read mode with cs_n_i and rd_n_i tied low, each write pulse yields the new sampled code on data_o once int_n_o falls.
- R11: During and after reset int_n_o = 1, ofl_n_o = 1, data_o = 0, and with cs_n_i high rdy_low_o = 0 and data_oe_o = 0.
- R12: A read-only conversion aborted by cs_n_i or rd_n_i rising before the time-out produces no result: int_n_o stays high, and data_o and ofl_n_o keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 1 | 0 = read-only protocol, 1 = write-then-read protocol |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe (input side of the shared pin, used when mode_i = 1) |
| code_i | input | DATA_W | Digitised input code |
| ovr_i | input | 1 | Input above full scale minus half an LSB |
| data_o | output | DATA_W | Output latch value for the data bus |
| data_oe_o | output | 1 | Data bus drive enable |
| int_n_o | output | 1 | Active-low conversion-complete interrupt |
| rdy_low_o | output | 1 | Open-drain pull-down enable of the shared pin (mode_i = 0) |
| ofl_n_o | output | 1 | Active-low overflow flag |

## Verification
Each protocol is exercised with extreme codes (0x00 and 0xFF with over-range set) and with random codes. In every run, code_i and ovr_i are inverted one cycle after the sampling edge, so a design that samples late shows the wrong word. Write-then-read runs are split into three kinds:
- Waiting for the timer checks the exact cycle of the interrupt.
- Reading early checks that the read access, not the timer, ends the conversion.
- Standalone runs check that a new write clears the interrupt.

Aborted reads and a held read in the wrong mode show that nothing starts or changes when it should not.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RO_CONV,
        ST_RO_HOLD,
        ST_WR_LOW,
        ST_LS_CONV
    } seq_state_t;

endpackage

// File: rtl/adc_seq_edges.sv
// Registers the previous level of each active-low control and flags edges.
module adc_seq_edges #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/adc_seq_timer.sv
// Down-counter standing in for an internal one-shot delay.
module adc_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             fire_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign fire_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/adc_bus_sequencer.sv
module adc_bus_sequencer
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RO_CYC = 140,
    parameter int LS_CYC = 76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [DATA_W-1:0] code_i,
    input  logic              ovr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              int_n_o,
    output logic              rdy_low_o,
    output logic              ofl_n_o
);

    localparam int NIB   = DATA_W / 2;
    localparam int MAXC  = (RO_CYC > LS_CYC) ? RO_CYC : LS_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_t state, nxt;

    logic [2:0] rise, fall;
    logic cs_rise, rd_rise, wr_rise, cs_fall, rd_fall, wr_fall;
    logic rd_begin;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_fire;

    logic start, ms_take, finish;

    logic [DATA_W-1:0] samp_q;
    logic              samp_ovr_q;
    logic [NIB-1:0]    ms_q;
    logic [NIB-1:0]    ms_sel;
    logic [DATA_W-1:0] out_q;
    logic              int_n_q;
    logic              ofl_n_q;

    adc_seq_edges #(.W(3)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({cs_n_i, rd_n_i, wr_n_i}),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign cs_rise = rise[2];
    assign rd_rise = rise[1];
    assign wr_rise = rise[0];
    assign cs_fall = fall[2];
    assign rd_fall = fall[1];
    assign wr_fall = fall[0];

    // A read access begins when the later of CS and RD goes low.
    assign rd_begin = (rd_fall && !cs_n_i) || (cs_fall && !rd_n_i);

    adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .fire_o (tmr_fire)
    );

    // Next-state and control decode
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_len  = '0;
        start    = 1'b0;
        ms_take  = 1'b0;
        finish   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!mode_i && !cs_n_i && !rd_n_i) begin
                    nxt      = ST_RO_CONV;
                    start    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(RO_CYC);
                end else if (mode_i && !cs_n_i && wr_fall) begin
                    nxt   = ST_WR_LOW;
                    start = 1'b1;
                end
            end
            ST_RO_CONV: begin
                if (cs_n_i || rd_n_i) begin
                    nxt = ST_IDLE;
                end else if (tmr_fire) begin
                    nxt    = ST_RO_HOLD;
                    finish = 1'b1;
                end
            end
            ST_RO_HOLD: begin
                if (cs_n_i || rd_n_i) begin
                    nxt = ST_IDLE;
                end
            end
            ST_WR_LOW: begin
                if (wr_rise) begin
                    nxt      = ST_LS_CONV;
                    ms_take  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(LS_CYC);
                end
            end
            ST_LS_CONV: begin
                if (rd_begin || tmr_fire) begin
                    nxt    = ST_IDLE;
                    finish = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Read-only mode has no write strobe, so the upper nibble comes straight from the sample.
    assign ms_sel = (state == ST_RO_CONV) ? samp_q[DATA_W-1:NIB] : ms_q;

    // Sample, half-latches and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q     <= '0;
            samp_ovr_q <= 1'b0;
            ms_q       <= '0;
            out_q      <= '0;
            int_n_q    <= 1'b1;
            ofl_n_q    <= 1'b1;
        end else begin
            if (start) begin
                samp_q     <= code_i;
                samp_ovr_q <= ovr_i;
                int_n_q    <= 1'b1;
            end
            if (ms_take) begin
                ms_q <= samp_q[DATA_W-1:NIB];
            end
            if (finish) begin
                out_q   <= {ms_sel, samp_q[NIB-1:0]};
                ofl_n_q <= ~samp_ovr_q;
                int_n_q <= 1'b0;
            end
            if (cs_rise || rd_rise) begin
                int_n_q <= 1'b1;
            end
        end
    end

    assign data_o    = out_q;
    assign data_oe_o = !cs_n_i && !rd_n_i;
    assign int_n_o   = int_n_q;
    assign ofl_n_o   = ofl_n_q;
    assign rdy_low_o = !mode_i && !cs_n_i && (state != ST_RO_HOLD);

    // The sample stays put for the whole conversion (R2, R4)
    assert_sample_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_LOW || state == ST_LS_CONV || state == ST_RO_CONV) |=> $stable(samp_q));

    // Ready is released once the read-only time-out completes
    assert_rdy_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RO_CONV && tmr_fire && !cs_n_i && !rd_n_i) |=> !rdy_low_o);

    // An early read access ends the lower-half conversion with INT low
    assert_early_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LS_CONV && rd_begin) |=> !int_n_o);

    // A rising CS or RD releases INT
    assert_int_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise || rd_rise) |=> int_n_o);

    // The overflow flag cannot move while the write strobe is held low
    assert_ofl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_LOW) |=> $stable(ofl_n_o));

endmodule

// File: tb/tb_adc_bus_sequencer.sv
`timescale 1ns/1ps
module tb_adc_bus_sequencer;

    localparam int CLK_NS    = 5;
    localparam int RO_CYC    = 700 / CLK_NS;
    localparam int LS_CYC    = 380 / CLK_NS;
    localparam int WR_CYC    = 250 / CLK_NS;
    localparam int EARLY_CYC = 250 / CLK_NS;
    localparam int DATA_W    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_i = 1'b0;
    logic cs_n_i = 1'b1;
    logic rd_n_i = 1'b1;
    logic wr_n_i = 1'b1;
    logic [DATA_W-1:0] code_i = '0;
    logic ovr_i = 1'b0;
    logic [DATA_W-1:0] data_o;
    logic data_oe_o, int_n_o, rdy_low_o, ofl_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] last_code = '0;
    logic last_ofl_n = 1'b1;

    always #(CLK_NS / 2.0) clk = ~clk;

    adc_bus_sequencer #(
        .DATA_W (DATA_W),
        .RO_CYC (RO_CYC),
        .LS_CYC (LS_CYC)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .cs_n_i    (cs_n_i),
        .rd_n_i    (rd_n_i),
        .wr_n_i    (wr_n_i),
        .code_i    (code_i),
        .ovr_i     (ovr_i),
        .data_o    (data_o),
        .data_oe_o (data_oe_o),
        .int_n_o   (int_n_o),
        .rdy_low_o (rdy_low_o),
        .ofl_n_o   (ofl_n_o)
    );

    function automatic logic [DATA_W-1:0] exp_word(input logic [DATA_W-1:0] c);
        return {c[DATA_W-1:DATA_W/2], c[DATA_W/2-1:0]};
    endfunction

    function automatic logic exp_ofl_n(input logic o);
        return ~o;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Read-only mode: one stretched read
    task automatic ro_read(input logic [DATA_W-1:0] c, input logic o);
        @(negedge clk);
        code_i = c; ovr_i = o; cs_n_i = 1'b0; rd_n_i = 1'b0;
        #1;
        chk(data_oe_o, 1, "R8", "bus enabled during read");
        chk(rdy_low_o, 1, "R3", "ready pulled low");
        @(negedge clk);
        code_i = ~c; ovr_i = ~o;
        repeat (RO_CYC - 1) @(negedge clk);
        chk(int_n_o, 1, "R2", "int before time-out");
        chk(rdy_low_o, 1, "R3", "ready still low");
        @(negedge clk);
        chk(int_n_o, 0, "R2", "int at time-out");
        chk(data_o, exp_word(c), "R2", "read-only data");
        chk(ofl_n_o, exp_ofl_n(o), "R9", "overflow flag");
        chk(rdy_low_o, 0, "R3", "ready released");
        last_code = exp_word(c); last_ofl_n = exp_ofl_n(o);
        rd_n_i = 1'b1;
        #1;
        chk(data_oe_o, 0, "R8", "bus off after read");
        @(negedge clk);
        chk(int_n_o, 1, "R7", "int release on rd rise");
        cs_n_i = 1'b1;
        @(negedge clk);
    endtask

    // Write-then-read mode, waiting for INT or reading early
    task automatic wr_conv(input logic [DATA_W-1:0] c, input logic o, input bit early);
        @(negedge clk);
        code_i = c; ovr_i = o; cs_n_i = 1'b0; wr_n_i = 1'b0;
        @(negedge clk);
        code_i = ~c; ovr_i = ~o;
        chk(rdy_low_o, 0, "R3", "no ready in write mode");
        repeat (WR_CYC - 1) @(negedge clk);
        wr_n_i = 1'b1;
        if (early) begin
            repeat (EARLY_CYC) @(negedge clk);
            chk(int_n_o, 1, "R6", "int before early read");
            rd_n_i = 1'b0;
            #1;
            chk(data_oe_o, 1, "R8", "bus on for early read");
            @(negedge clk);
            chk(int_n_o, 0, "R6", "int forced by early read");
            chk(data_o, exp_word(c), "R6", "early read data");
            chk(ofl_n_o, exp_ofl_n(o), "R9", "overflow flag");
        end else begin
            repeat (LS_CYC) @(negedge clk);
            chk(int_n_o, 1, "R5", "int before lower half done");
            chk(ofl_n_o, last_ofl_n, "R9", "overflow held");
            @(negedge clk);
            chk(int_n_o, 0, "R5", "int after lower half");
            chk(ofl_n_o, exp_ofl_n(o), "R9", "overflow flag");
            rd_n_i = 1'b0;
            #1;
            chk(data_o, exp_word(c), "R5", "write-then-read data");
            chk(data_oe_o, 1, "R8", "bus on for read");
        end
        last_code = exp_word(c); last_ofl_n = exp_ofl_n(o);
        @(negedge clk);
        rd_n_i = 1'b1;
        @(negedge clk);
        chk(int_n_o, 1, "R7", "int release on rd rise");
        cs_n_i = 1'b1;
        @(negedge clk);
    endtask

    // Standalone: CS and RD already low, mode high
    task automatic standalone(input logic [DATA_W-1:0] c, input logic o);
        @(negedge clk);
        code_i = c; ovr_i = o; wr_n_i = 1'b0;
        @(negedge clk);
        chk(int_n_o, 1, "R7", "new conversion clears int");
        code_i = ~c; ovr_i = ~o;
        repeat (WR_CYC - 1) @(negedge clk);
        wr_n_i = 1'b1;
        repeat (LS_CYC + 1) @(negedge clk);
        chk(int_n_o, 0, "R10", "standalone int");
        chk(data_o, exp_word(c), "R10", "standalone data");
        chk(data_oe_o, 1, "R10", "standalone bus on");
        chk(ofl_n_o, exp_ofl_n(o), "R9", "overflow flag");
        last_code = exp_word(c); last_ofl_n = exp_ofl_n(o);
    endtask

    initial begin
        #(CLK_NS * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd1357);
        repeat (3) @(negedge clk);
        chk(int_n_o, 1, "R11", "int in reset");
        chk(ofl_n_o, 1, "R11", "ofl in reset");
        chk(data_o, 0, "R11", "data in reset");
        chk(rdy_low_o, 0, "R11", "ready in reset");
        chk(data_oe_o, 0, "R11", "bus in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(int_n_o, 1, "R11", "int after reset");

        // Directed corners
        ro_read(8'hFF, 1'b1);
        ro_read(8'h00, 1'b0);
        mode_i = 1'b1;
        wr_conv(8'hA5, 1'b1, 1'b0);
        wr_conv(8'h3C, 1'b0, 1'b1);

        // R1: held read in write-then-read mode starts nothing
        @(negedge clk);
        cs_n_i = 1'b0; rd_n_i = 1'b0; code_i = 8'h11;
        repeat (RO_CYC + 5) @(negedge clk);
        chk(int_n_o, 1, "R1", "no conversion in write mode");
        chk(data_o, last_code, "R1", "latch unchanged");

        // Standalone with CS and RD still low
        standalone(8'h5A, 1'b0);
        standalone(8'hC3, 1'b1);
        standalone(8'h0F, 1'b0);
        @(negedge clk);
        cs_n_i = 1'b1; rd_n_i = 1'b1;
        @(negedge clk);
        mode_i = 1'b0;

        // R12: aborted read-only conversion
        @(negedge clk);
        cs_n_i = 1'b0; rd_n_i = 1'b0; code_i = 8'h77; ovr_i = 1'b1;
        repeat (10) @(negedge clk);
        rd_n_i = 1'b1;
        repeat (RO_CYC + 5) @(negedge clk);
        chk(int_n_o, 1, "R12", "no int after abort");
        chk(ofl_n_o, last_ofl_n, "R12", "overflow unchanged");
        cs_n_i = 1'b1;
        @(negedge clk);
        mode_i = 1'b1;
        @(negedge clk);
        cs_n_i = 1'b0; rd_n_i = 1'b0;
        #1;
        chk(data_o, last_code, "R12", "latch unchanged after abort");
        @(negedge clk);
        cs_n_i = 1'b1; rd_n_i = 1'b1;
        @(negedge clk);

        // Random mix
        for (int i = 0; i < 14; i++) begin
            int kind;
            logic [DATA_W-1:0] c;
            logic o;
            kind = int'($urandom_range(0, 2));
            c = DATA_W'($urandom_range(0, 255));
            o = ($urandom_range(0, 3) == 0);
            if (kind == 0) begin
                mode_i = 1'b0;
                ro_read(c, o);
            end else begin
                mode_i = 1'b1;
                wr_conv(c, o, kind == 2);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule